// File: doc/BRIEF.md
# Flash Erase-Suspend Status Engine

This block models the internal write state machine of a parallel NOR flash at the cycle level. It takes decoded command bytes with an address and a data word, and runs program and sector-erase operations whose durations are set by cycle-count parameters. While an operation runs it returns polling status in place of array data and holds the ready/busy output low. The array is a small register file: it resets to the erased value (all ones), and a program can only clear bits.

A running erase can be suspended. Suspension takes effect after a fixed latency, counted in clock cycles, with a default of 10 µs at the 125 MHz model clock. While the erase is suspended, the rest of the array can be read and programmed. Reads inside the suspended sector return a distinct status pattern. A resume command continues the erase from the exact cycle count where it stopped. The suspended sector is reported on a port so that surrounding logic can flag accesses to it.

Top module: `flash_susp_engine`

## Requirements
- R1: After reset the engine is idle: `ry_by`=1, `susp_active`=0, and every array word reads FFh.
- R2: Command code A0h programs the word at `cmd_addr`. `ry_by` is low for exactly PROG_CYC cycles starting in the cycle after acceptance. Afterwards the word reads (old value AND `cmd_data`).
- R3: While a program runs, a read at any address returns a status word. Bit 7 is the complement of bit 7 of the data being programmed, bit 6 flips between successive status reads, bit 2 is 1, and every other bit is 0.
- R4: Command code 50h erases the sector selected by the upper SECT_W address bits. `ry_by` is low for ERASE_CYC cycles, then every word of that sector reads FFh, and other sectors keep their contents.
- R5: While an erase runs, including the suspend latency, reads return bit 7 = 0 and bits 6 and 2 equal to each other and flipping on each status read; other bits are 0.
- R6: Code B0h during an erase keeps `ry_by` low for exactly SUSP_LAT cycles. After that, `ry_by`=1, `susp_active`=1 and `susp_sector` holds the erasing sector.
- R7: While suspended, reads outside the suspended sector return array data. Reads inside it return bits 7 and 6 = 1, bit 2 flipping on each such read, and other bits 0.
- R8: While suspended, a program to another sector runs as in R2 and the engine then stays suspended. A program to the suspended sector is ignored, and `ry_by` stays 1.
- R9: Code 30h at any address while suspended resumes the erase. The erase then finishes after exactly the cycles it had left, so the counting cycles before and after the suspension add up to ERASE_CYC.
- R10: B0h with no erase running, and 30h when not suspended, are ignored. Any command while a program runs is ignored, as is an erase command while suspended.
- R11: When B0h arrives in the final cycle of an erase, the erase completes and the suspend is ignored: `ry_by`=1 and `susp_active`=0 in the next cycle.
- R12: Command codes other than A0h, 50h, B0h and 30h have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 8 | Decoded command byte |
| cmd_addr | input | ADDR_W | Command word address |
| cmd_data | input | DATA_W | Program data |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | DATA_W | Read result, valid the cycle after `rd_en` |
| ry_by | output | 1 | 1 = ready, 0 = program/erase in progress |
| susp_active | output | 1 | An erase is suspended |
| susp_sector | output | SECT_W | Sector of the erase in progress or suspended |

## Verification
The erase's last counting cycle and an arriving suspend command can land on the same clock edge. The bench provokes this by issuing B0h exactly ERASE_CYC-1 cycles after the erase was accepted. It judges the outcome by requiring `ry_by` high, `susp_active` low and the sector reading FFh right after that edge. It then repeats the sequence one cycle earlier and requires the suspend to be taken, and the resumed erase to need only its two remaining cycles.

// File: rtl/fse_pkg.sv
package fse_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_PROG,
    WS_ERASE,
    WS_SWAIT,
    WS_SUSP,
    WS_SPROG
  } ws_state_t;

  localparam logic [7:0] OP_PROGRAM = 8'hA0;
  localparam logic [7:0] OP_ERASE   = 8'h50;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;
  localparam logic [7:0] OP_RESUME  = 8'h30;

  function automatic logic st_busy(input ws_state_t st);
    return (st == WS_PROG) || (st == WS_ERASE) || (st == WS_SWAIT) || (st == WS_SPROG);
  endfunction

  function automatic logic st_programming(input ws_state_t st);
    return (st == WS_PROG) || (st == WS_SPROG);
  endfunction

  // Polling word while an operation runs: bit7 poll, bit6 toggle, bit2 erase toggle
  function automatic logic [7:0] busy_status(input ws_state_t st, input logic pdata7,
                                             input logic tog);
    logic prog;
    prog = st_programming(st);
    return {(prog ? ~pdata7 : 1'b0), tog, 3'b000, (prog ? 1'b1 : tog), 2'b00};
  endfunction

  // Word seen inside the suspended sector
  function automatic logic [7:0] susp_status(input logic tog);
    return {2'b11, 3'b000, tog, 2'b00};
  endfunction

endpackage

// File: rtl/fse_array.sv
module fse_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              er_en,
  input  logic [SECT_W-1:0] er_sec,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH*DATA_W-1:0] flat;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    localparam logic [SECT_W-1:0] W_SEC = SECT_W'(w >> (ADDR_W - SECT_W));
    logic [DATA_W-1:0] word_q;
    logic hit_er, hit_wr;

    assign hit_er = er_en && (er_sec == W_SEC);
    assign hit_wr = wr_en && (wr_addr == ADDR_W'(w));

    always_ff @(posedge clk) begin
      if (!rst_n)      word_q <= '1;
      else if (hit_er) word_q <= '1;
      else if (hit_wr) word_q <= word_q & wr_data;
    end
    assign flat[w*DATA_W +: DATA_W] = word_q;

    AST_PROG_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_wr && !hit_er) |=> ((word_q & ~$past(word_q)) == '0)); // R2
    AST_SECTOR_ERASED: assert property (@(posedge clk) disable iff (!rst_n)
      hit_er |=> (word_q == '1)); // R4
  end

  assign rd_word = flat[rd_addr*DATA_W +: DATA_W];

endmodule

// File: rtl/fse_seq.sv
module fse_seq
  import fse_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 12,
  parameter int ERASE_CYC = 64,
  parameter int SUSP_LAT  = 1250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  output ws_state_t         state_o,
  output logic              prog_we,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              erase_we,
  output logic [SECT_W-1:0] erase_sec
);
  localparam int PC_W = $clog2(PROG_CYC + 1);
  localparam int EC_W = $clog2(ERASE_CYC + 1);
  localparam int LC_W = $clog2(SUSP_LAT + 1);
  localparam int AG_W = LC_W + 1;

  ws_state_t         state_q, state_d;
  logic [PC_W-1:0]   pcnt_q;
  logic [EC_W-1:0]   ecnt_q;
  logic [LC_W-1:0]   lcnt_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_data_q;
  logic [SECT_W-1:0] er_sec_q;

  // Named events
  logic cmd_sec_free, acc_prog, acc_erase, acc_susp, acc_resume;
  logic prog_fin, erase_fin, lat_fin;

  assign cmd_sec_free = cmd_addr[ADDR_W-1 -: SECT_W] != er_sec_q;
  assign acc_prog   = cmd_valid && (cmd_code == OP_PROGRAM) &&
                      ((state_q == WS_IDLE) || ((state_q == WS_SUSP) && cmd_sec_free));
  assign acc_erase  = cmd_valid && (cmd_code == OP_ERASE) && (state_q == WS_IDLE);
  assign acc_susp   = cmd_valid && (cmd_code == OP_SUSPEND) && (state_q == WS_ERASE) &&
                      (ecnt_q != '0);
  assign acc_resume = cmd_valid && (cmd_code == OP_RESUME) && (state_q == WS_SUSP);
  assign prog_fin   = st_programming(state_q) && (pcnt_q == '0);
  assign erase_fin  = (state_q == WS_ERASE) && (ecnt_q == '0);
  assign lat_fin    = (state_q == WS_SWAIT) && (lcnt_q == '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      WS_IDLE:  if (acc_prog) state_d = WS_PROG;
                else if (acc_erase) state_d = WS_ERASE;
      WS_PROG:  if (prog_fin) state_d = WS_IDLE;
      WS_ERASE: if (erase_fin) state_d = WS_IDLE;
                else if (acc_susp) state_d = WS_SWAIT;
      WS_SWAIT: if (lat_fin) state_d = WS_SUSP;
      WS_SUSP:  if (acc_resume) state_d = WS_ERASE;
                else if (acc_prog) state_d = WS_SPROG;
      WS_SPROG: if (prog_fin) state_d = WS_SUSP;
      default:  state_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= WS_IDLE;
      pcnt_q    <= '0;
      ecnt_q    <= '0;
      lcnt_q    <= '0;
      op_addr_q <= '0;
      op_data_q <= '0;
      er_sec_q  <= '0;
    end else begin
      state_q <= state_d;
      if (acc_prog) begin
        pcnt_q    <= PC_W'(PROG_CYC - 1);
        op_addr_q <= cmd_addr;
        op_data_q <= cmd_data;
      end else if (st_programming(state_q) && pcnt_q != '0) begin
        pcnt_q <= pcnt_q - 1'b1;
      end
      if (acc_erase) begin
        ecnt_q   <= EC_W'(ERASE_CYC - 1);
        er_sec_q <= cmd_addr[ADDR_W-1 -: SECT_W];
      end else if ((state_q == WS_ERASE) && !acc_susp && ecnt_q != '0) begin
        ecnt_q <= ecnt_q - 1'b1;
      end
      if (acc_susp) lcnt_q <= LC_W'(SUSP_LAT - 1);
      else if ((state_q == WS_SWAIT) && lcnt_q != '0) lcnt_q <= lcnt_q - 1'b1;
    end
  end

  assign state_o   = state_q;
  assign prog_we   = prog_fin;
  assign prog_addr = op_addr_q;
  assign prog_data = op_data_q;
  assign erase_we  = erase_fin;
  assign erase_sec = er_sec_q;

  // Checker: independent age of the suspend window
  logic [AG_W-1:0] swait_age;
  always_ff @(posedge clk) begin
    if (!rst_n || state_q != WS_SWAIT) swait_age <= '0;
    else swait_age <= swait_age + 1'b1;
  end

  AST_SUSP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_SWAIT) |-> (swait_age < AG_W'(SUSP_LAT))); // R6
  AST_ERASE_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == WS_SWAIT) || (state_q == WS_SUSP) || (state_q == WS_SPROG)) |=>
      $stable(ecnt_q)); // R9
  AST_SPROG_OTHER_SECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_we && state_q == WS_SPROG) |-> (prog_addr[ADDR_W-1 -: SECT_W] != er_sec_q)); // R8
  AST_WRITE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_we, erase_we})); // R2
  AST_ERASE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_we |=> (state_q == WS_IDLE)); // R11
  AST_IDLE_NO_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WS_IDLE) |=> (state_q != WS_SWAIT && state_q != WS_SUSP)); // R10

endmodule

// File: rtl/fse_rdport.sv
module fse_rdport
  import fse_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int SECT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  ws_state_t         state,
  input  logic [SECT_W-1:0] er_sec,
  input  logic              pdata7,
  input  logic [DATA_W-1:0] arr_word,
  output logic [DATA_W-1:0] rd_data
);
  logic in_susp_sec, busy_rd, stat_rd, tog_q;
  logic [DATA_W-1:0] rd_q;

  assign in_susp_sec = (state == WS_SUSP || state == WS_SPROG) &&
                       (rd_addr[ADDR_W-1 -: SECT_W] == er_sec);
  assign busy_rd = rd_en && st_busy(state);
  assign stat_rd = busy_rd || (rd_en && in_susp_sec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tog_q <= 1'b0;
      rd_q  <= '0;
    end else begin
      if (stat_rd) tog_q <= ~tog_q;
      if (rd_en) begin
        if (st_busy(state))   rd_q <= DATA_W'(busy_status(state, pdata7, tog_q));
        else if (in_susp_sec) rd_q <= DATA_W'(susp_status(tog_q));
        else                  rd_q <= arr_word;
      end
    end
  end

  assign rd_data = rd_q;

  AST_ERASE_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (state == WS_ERASE || state == WS_SWAIT)) |=> !rd_data[7]); // R5
  AST_SUSP_SEC_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !st_busy(state) && in_susp_sec) |=> (rd_data[7:6] == 2'b11)); // R7
  AST_PROG_DQ2_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && st_programming(state)) |=> rd_data[2]); // R3

endmodule

// File: rtl/flash_susp_engine.sv
module flash_susp_engine
  import fse_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int SECT_W    = 2,
  parameter int PROG_CYC  = 12,
  parameter int ERASE_CYC = 64,
  parameter int SUSP_LAT  = 1250
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              ry_by,
  output logic              susp_active,
  output logic [SECT_W-1:0] susp_sector
);
  ws_state_t         state;
  logic              prog_we, erase_we;
  logic [ADDR_W-1:0] prog_addr;
  logic [DATA_W-1:0] prog_data, arr_word;
  logic [SECT_W-1:0] erase_sec;

  fse_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .SUSP_LAT(SUSP_LAT)
  ) seq_i (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .state_o(state), .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_we(erase_we), .erase_sec(erase_sec)
  );

  fse_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) arr_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(prog_we), .wr_addr(prog_addr), .wr_data(prog_data),
    .er_en(erase_we), .er_sec(erase_sec),
    .rd_addr(rd_addr), .rd_word(arr_word)
  );

  fse_rdport #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) rdp_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .state(state), .er_sec(erase_sec), .pdata7(prog_data[7]),
    .arr_word(arr_word), .rd_data(rd_data)
  );

  assign ry_by       = !st_busy(state);
  assign susp_active = (state == WS_SUSP) || (state == WS_SPROG);
  assign susp_sector = erase_sec;

  AST_READY_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ry_by) |-> $past(prog_we || erase_we || state == WS_SWAIT)); // R2
  AST_SUSP_SECTOR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (susp_active && $past(susp_active)) |-> $stable(susp_sector)); // R6

endmodule

// File: tb/flash_susp_engine_tb.sv
module flash_susp_engine_tb_top;
  localparam int ADDR_W = 6, DATA_W = 8, SECT_W = 2;
  localparam int PROG_CYC = 12, ERASE_CYC = 64, SUSP_LAT = 1250;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_code = '0;
  logic [ADDR_W-1:0] cmd_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] cmd_data = '0, rd_data;
  logic rd_en = 1'b0, ry_by, susp_active;
  logic [SECT_W-1:0] susp_sector;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  flash_susp_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .SUSP_LAT(SUSP_LAT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .ry_by(ry_by), .susp_active(susp_active), .susp_sector(susp_sector)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] code, input logic [ADDR_W-1:0] a,
                     input logic [DATA_W-1:0] d);
    cmd_valid = 1'b1; cmd_code = code; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ry_by && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk(ry_by == 1'b1, "R1", "ready after reset", ry_by, 1);
    chk(susp_active == 1'b0, "R1", "not suspended after reset", susp_active, 0);
    rd(6'h00, d); chk(d == 8'hFF, "R1", "word 00 erased", d, 8'hFF);
    rd(6'h3F, d); chk(d == 8'hFF, "R1", "word 3F erased", d, 8'hFF);
  endtask

  task automatic t_program;
    logic [7:0] a, b;
    int n;
    cmd(8'hA0, 6'h05, 8'h3C);
    chk(ry_by == 1'b0, "R2", "busy after program", ry_by, 0);
    rd(6'h30, a); rd(6'h30, b);
    chk(a[7] == 1'b1, "R3", "poll bit complement", a[7], 1);
    chk(a[6] != b[6], "R3", "toggle between reads", b[6], ~a[6]);
    chk((a & 8'h3B) == 8'h00 && a[2], "R3", "status layout", a, 8'h04);
    wait_ready(n);
    chk(n == PROG_CYC - 2, "R2", "program busy cycles", n, PROG_CYC - 2);
    rd(6'h05, a); chk(a == 8'h3C, "R2", "programmed word", a, 8'h3C);
    cmd(8'hA0, 6'h05, 8'hF0);
    rd(6'h05, a);
    chk(a[7] == 1'b0, "R3", "poll bit for data bit7=1", a[7], 0);
    wait_ready(n);
    chk(n == PROG_CYC - 1, "R2", "second program cycles", n, PROG_CYC - 1);
    rd(6'h05, a); chk(a == 8'h30, "R2", "program clears bits only", a, 8'h30);
  endtask

  task automatic t_erase;
    logic [7:0] a, b;
    int n;
    cmd(8'hA0, 6'h12, 8'h00); wait_ready(n);
    cmd(8'h50, 6'h1A, 8'h00);
    rd(6'h12, a); rd(6'h00, b);
    chk(a[7] == 1'b0, "R5", "erase poll bit", a[7], 0);
    chk(a[6] == a[2] && a[6] != b[6] && b[2] != a[2], "R5", "erase toggles", b, ~a);
    wait_ready(n);
    chk(n == ERASE_CYC - 2, "R4", "erase busy cycles", n, ERASE_CYC - 2);
    rd(6'h12, a); chk(a == 8'hFF, "R4", "sector word erased", a, 8'hFF);
    rd(6'h05, a); chk(a == 8'h30, "R4", "other sector kept", a, 8'h30);
  endtask

  task automatic t_suspend_resume;
    logic [7:0] a, b;
    int n;
    cmd(8'hA0, 6'h22, 8'h55); wait_ready(n);
    cmd(8'h50, 6'h20, 8'h00);
    repeat (5) @(negedge clk);
    cmd(8'hB0, 6'h00, 8'h00);
    rd(6'h22, a);
    chk(a[7] == 1'b0, "R5", "poll low in suspend latency", a[7], 0);
    wait_ready(n);
    chk(n == SUSP_LAT - 1, "R6", "suspend latency", n, SUSP_LAT - 1);
    chk(susp_active == 1'b1, "R6", "suspended flag", susp_active, 1);
    chk(susp_sector == 2'd2, "R6", "suspended sector", susp_sector, 2);
    rd(6'h05, a); chk(a == 8'h30, "R7", "read other sector", a, 8'h30);
    rd(6'h22, a); rd(6'h2F, b);
    chk((a & 8'hFB) == 8'hC0 && (b & 8'hFB) == 8'hC0, "R7", "suspended sector word", a, 8'hC0);
    chk(a[2] != b[2], "R7", "bit2 toggles in suspended sector", b[2], ~a[2]);
    cmd(8'hA0, 6'h23, 8'h00);
    chk(ry_by == 1'b1, "R8", "program to suspended sector ignored", ry_by, 1);
    cmd(8'hA0, 6'h06, 8'h0F);
    chk(ry_by == 1'b0, "R8", "program elsewhere starts", ry_by, 0);
    wait_ready(n);
    chk(n == PROG_CYC, "R8", "program in suspend cycles", n, PROG_CYC);
    chk(susp_active == 1'b1, "R8", "still suspended", susp_active, 1);
    rd(6'h06, a); chk(a == 8'h0F, "R8", "program in suspend data", a, 8'h0F);
    cmd(8'h50, 6'h00, 8'h00);
    chk(ry_by == 1'b1, "R10", "erase while suspended ignored", ry_by, 1);
    cmd(8'hB0, 6'h00, 8'h00);
    chk(ry_by == 1'b1 && susp_active, "R10", "suspend while suspended ignored", ry_by, 1);
    cmd(8'h30, 6'h3F, 8'h00);
    chk(ry_by == 1'b0, "R9", "resume restarts erase", ry_by, 0);
    wait_ready(n);
    chk(n == ERASE_CYC - 5, "R9", "remaining erase cycles", n, ERASE_CYC - 5);
    chk(susp_active == 1'b0, "R9", "suspend cleared", susp_active, 0);
    rd(6'h22, a); chk(a == 8'hFF, "R9", "resumed erase done", a, 8'hFF);
    rd(6'h06, a); chk(a == 8'h0F, "R4", "neighbour sector intact", a, 8'h0F);
  endtask

  task automatic t_ignored;
    logic [7:0] a;
    int n;
    cmd(8'hB0, 6'h00, 8'h00);
    chk(ry_by && !susp_active, "R10", "suspend when idle ignored", ry_by, 1);
    cmd(8'h30, 6'h10, 8'h00);
    chk(ry_by == 1'b1, "R10", "resume when idle ignored", ry_by, 1);
    cmd(8'h90, 6'h3A, 8'h00);
    chk(ry_by == 1'b1, "R12", "unknown code ignored", ry_by, 1);
    rd(6'h3A, a); chk(a == 8'hFF, "R12", "unknown code leaves array", a, 8'hFF);
    cmd(8'hA0, 6'h07, 8'h00);
    cmd(8'hA0, 6'h08, 8'h00);
    cmd(8'hB0, 6'h07, 8'h00);
    wait_ready(n);
    chk(n == PROG_CYC - 2, "R10", "program not disturbed", n, PROG_CYC - 2);
    chk(susp_active == 1'b0, "R10", "suspend during program ignored", susp_active, 0);
    rd(6'h08, a); chk(a == 8'hFF, "R10", "program while busy ignored", a, 8'hFF);
    rd(6'h07, a); chk(a == 8'h00, "R2", "first program landed", a, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] a;
    int n;
    cmd(8'hA0, 6'h31, 8'h00); wait_ready(n);
    cmd(8'h50, 6'h30, 8'h00);
    repeat (ERASE_CYC - 1) @(negedge clk);
    cmd(8'hB0, 6'h30, 8'h00);
    chk(ry_by == 1'b1, "R11", "erase completes over suspend", ry_by, 1);
    chk(susp_active == 1'b0, "R11", "suspend dropped", susp_active, 0);
    rd(6'h31, a); chk(a == 8'hFF, "R11", "sector erased", a, 8'hFF);
    cmd(8'hA0, 6'h31, 8'h00); wait_ready(n);
    cmd(8'h50, 6'h30, 8'h00);
    repeat (ERASE_CYC - 2) @(negedge clk);
    cmd(8'hB0, 6'h30, 8'h00);
    chk(ry_by == 1'b0, "R6", "suspend one cycle earlier taken", ry_by, 0);
    wait_ready(n);
    chk(susp_active == 1'b1, "R6", "suspended near end", susp_active, 1);
    cmd(8'h30, 6'h00, 8'h00);
    wait_ready(n);
    chk(n == 2, "R9", "two cycles left after resume", n, 2);
    rd(6'h31, a); chk(a == 8'hFF, "R9", "late erase done", a, 8'hFF);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_erase();
        t_suspend_resume();
        t_ignored();
        t_collide();
      end
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    summary();
    $finish;
  end

endmodule